// File: doc/BRIEF.md
# Complementary PWM Pair with Dead-Band Delay

This block produces two active-high gate-drive signals for a half-bridge: a primary pulse-width-modulated output and its complement. A free-running timer advances once per enabled tick and restarts at zero in the tick after it has reached the period value. The duty value sets how many ticks of each period the primary is asserted. The remaining ticks belong to the complement.

To keep the two power switches from conducting at the same time, each output's rising edge is held back by a programmable dead-band of 0 to 127 ticks, counted from the tick on which that output's undelayed level went high. Falling edges are never delayed. If the dead-band is as long as an output's active interval or longer, that output stays low for the whole interval. Clearing the enable holds both outputs low and parks the timer. When enable is set again, the block restarts at timer zero with a fresh duty value.

All state advances only on clock edges where `tick_en` is sampled high, and both outputs are registered. A tick sampled at an edge is therefore visible on the outputs just after that edge.

Top module: `cpwm_deadband`

## Requirements
- R1: Counting from the first enabled tick as tick 0, the timer value on tick k is k mod (period+1). After the timer reaches the period value, the next tick starts a new period at zero.
- R2: The duty value is captured on the tick where the timer is zero, and also on the first tick after enable. A write in the middle of a period only changes the waveform from the next period onward.
- R3: The primary's undelayed level is high on ticks where timer < captured duty. The complement's undelayed level is its inverse.
- R4: Each output goes high only after its undelayed level has been high for more than `deadband` consecutive ticks. The run length is counted from 0 on the tick of the rising transition, or on the first tick after enable, and saturates at 127. Each output falls on the same tick its undelayed level falls.
- R5: If the dead-band is at least as long as an output's active interval, that output stays low for the whole interval.
- R6: With a dead-band of 0, exactly one of the two outputs is high after every enabled tick.
- R7: A captured duty of 0 keeps the primary low for the whole period. A captured duty greater than the period keeps it high for the whole period.
- R8: A clock edge with `enable` low drives both outputs low and resets the timer and the dead-band counts. Re-enabling restarts at timer 0.
- R9: On an edge with `tick_en` low, no output changes.
- R10: `out_pri` and `out_cmp` are never high in the same cycle.
- R11: While `rst_n` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Advances the timer and dead-band counts on this edge |
| enable | input | 1 | Run control; low holds outputs low and state cleared |
| period | input | CNT_W | Last timer value of a period |
| duty | input | CNT_W | Primary on-time in ticks, captured at period start |
| deadband | input | DB_W | Rising-edge delay in ticks, 0 to 127 |
| out_pri | output | 1 | Primary PWM output, active high |
| out_cmp | output | 1 | Complementary PWM output, active high |

## Verification
The bench goes after the edges where a wrong design would short the bridge or drop a pulse.

- **Dead-band longer than an active interval.** A wrong design would glitch the output high late in the interval, or carry the count across into the next period.
- **Duty of zero and duty above the period.** A missing saturation case would emit a one-tick sliver on the wrong output at the wrap.
- **Mid-period duty write.** A design that does not capture duty at the boundary would cut the current pulse short.
- **Tick stalls and disable/re-enable.** These expose counters that run on every clock, or that keep a stale timer or dead-band count across the restart.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int unsigned CNT_W_DEF = 8;
  localparam int unsigned DB_W_DEF  = 7;
  localparam int unsigned N_LANES   = 2;
  typedef enum logic {LANE_PRI = 1'b0, LANE_CMP = 1'b1} lane_e;
endpackage

// File: rtl/cpwm_period_timer.sv
module cpwm_period_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic             raw_nxt,
  output logic             restart
);
  logic             run_q;
  logic [CNT_W-1:0] tmr_q, tmr_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  logic             at_bnd;

  // next-state: a boundary is either the first tick after enable or a wrap
  always_comb begin
    at_bnd = !run_q || (tmr_q == period);
    tmr_d  = at_bnd ? '0 : tmr_q + 1'b1;
    duty_d = at_bnd ? duty : duty_q;
  end

  assign raw_nxt = (tmr_d < duty_d);
  assign restart = !run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      tmr_q  <= '0;
      duty_q <= '0;
    end else if (!enable) begin
      run_q  <= 1'b0;
      tmr_q  <= '0;
      duty_q <= '0;
    end else if (tick) begin
      run_q  <= 1'b1;
      tmr_q  <= tmr_d;
      duty_q <= duty_d;
    end
  end
endmodule

// File: rtl/cpwm_db_gate.sv
module cpwm_db_gate #(
  parameter int unsigned DB_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            tick,
  input  logic            raw_in,
  input  logic            restart,
  input  logic [DB_W-1:0] deadband,
  output logic            drive
);
  logic            raw_q;
  logic [DB_W-1:0] cnt_q, cnt_d;
  logic            drv_q, drv_d;

  // next-state: run length of the undelayed level, saturating
  always_comb begin
    if (raw_in && raw_q && !restart)
      cnt_d = (cnt_q == {DB_W{1'b1}}) ? cnt_q : cnt_q + 1'b1;
    else
      cnt_d = '0;
    drv_d = raw_in && (cnt_d >= deadband);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      cnt_q <= '0;
      drv_q <= 1'b0;
    end else if (!enable) begin
      raw_q <= 1'b0;
      cnt_q <= '0;
      drv_q <= 1'b0;
    end else if (tick) begin
      raw_q <= raw_in;
      cnt_q <= cnt_d;
      drv_q <= drv_d;
    end
  end

  assign drive = drv_q;
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
  import cpwm_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned DB_W  = DB_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             enable,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  input  logic [DB_W-1:0]  deadband,
  output logic             out_pri,
  output logic             out_cmp
);
  logic [1:0]         rst_sync_q;
  logic               rst_ok;
  logic               raw_nxt;
  logic               restart;
  logic [N_LANES-1:0] lane_drv;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  cpwm_period_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_ok),
    .enable  (enable),
    .tick    (tick_en),
    .period  (period),
    .duty    (duty),
    .raw_nxt (raw_nxt),
    .restart (restart)
  );

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    localparam logic INV = (i == int'(LANE_CMP));
    cpwm_db_gate #(.DB_W(DB_W)) u_gate (
      .clk      (clk),
      .rst_n    (rst_ok),
      .enable   (enable),
      .tick     (tick_en),
      .raw_in   (raw_nxt ^ INV),
      .restart  (restart),
      .deadband (deadband),
      .drive    (lane_drv[i])
    );
  end

  assign out_pri = lane_drv[LANE_PRI];
  assign out_cmp = lane_drv[LANE_CMP];
endmodule

// File: rtl/cpwm_deadband_chk.sv
module cpwm_deadband_chk #(
  parameter int unsigned DB_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_en,
  input logic            enable,
  input logic [DB_W-1:0] deadband,
  input logic            out_pri,
  input logic            out_cmp
);
  // R10: shoot-through guard
  a_r10_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_pri && out_cmp));

  // R8: disabled edge forces both outputs low
  a_r8_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!out_pri && !out_cmp));

  // R9: no tick, no change
  a_r9_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick_en) |=> ($stable(out_pri) && $stable(out_cmp)));

  // R6: zero dead-band gives exact complement
  a_r6_zero_db_complement: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick_en && (deadband == '0)) |=> (out_pri ^ out_cmp));
endmodule

bind cpwm_deadband cpwm_deadband_chk #(.DB_W(DB_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_ok),
  .tick_en  (tick_en),
  .enable   (enable),
  .deadband (deadband),
  .out_pri  (out_pri),
  .out_cmp  (out_cmp)
);

// File: tb/tb_cpwm_deadband.sv
module tb_cpwm_deadband;
  localparam int CNT_W = 8;
  localparam int DB_W  = 7;
  localparam int SAT   = (1 << DB_W) - 1;

  typedef struct packed {
    int p; int d; int b; int n; int gap; int req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{9, 4, 0, 30, 0, 6},
    '{9, 4, 2, 30, 0, 4},
    '{9, 0, 3, 30, 0, 7},
    '{9, 12, 3, 30, 0, 7},
    '{9, 3, 5, 30, 0, 5},
    '{4, 2, 3, 20, 2, 5},
    '{15, 8, 127, 40, 0, 5},
    '{0, 1, 0, 10, 0, 1},
    '{20, 10, 4, 60, 1, 3}
  };

  logic clk, rst_n, tick_en, enable;
  logic [CNT_W-1:0] period, duty;
  logic [DB_W-1:0]  deadband;
  logic out_pri, out_cmp;

  int n_chk, n_fail;
  bit done;
  int k, mduty, pc, cc;
  bit prev_raw, exp_p, exp_c;

  cpwm_deadband #(.CNT_W(CNT_W), .DB_W(DB_W)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .enable(enable),
    .period(period), .duty(duty), .deadband(deadband),
    .out_pri(out_pri), .out_cmp(out_cmp)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic string tag(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic model_reset();
    k = 0; pc = 0; cc = 0; prev_raw = 1'b0; exp_p = 1'b0; exp_c = 1'b0;
  endtask

  // reference behaviour from R1..R4 in terms of tick index
  task automatic model_step();
    int t;
    bit raw;
    t = k % (int'(period) + 1);
    if (t == 0) mduty = int'(duty);
    raw = (t < mduty);
    if (k > 0 && raw && prev_raw) pc = (pc < SAT) ? pc + 1 : pc; else pc = 0;
    if (k > 0 && !raw && !prev_raw) cc = (cc < SAT) ? cc + 1 : cc; else cc = 0;
    exp_p = raw && (pc >= int'(deadband));
    exp_c = !raw && (cc >= int'(deadband));
    prev_raw = raw;
    k++;
  endtask

  task automatic check_out(input string t);
    n_chk++;
    if (out_pri !== exp_p || out_cmp !== exp_c) begin
      n_fail++;
      $display("FAIL %s: pri/cmp actual %b%b expected %b%b", t, out_pri, out_cmp, exp_p, exp_c);
    end
    n_chk++;
    if (out_pri === 1'b1 && out_cmp === 1'b1) begin
      n_fail++;
      $display("FAIL R10: both high, actual 11 expected not 11");
    end
  endtask

  // called at a negedge; applies one edge and checks after it
  task automatic cycle(input bit tk, input string t);
    tick_en = tk;
    @(posedge clk);
    @(negedge clk);
    if (!enable) model_reset();
    else if (tk) model_step();
    check_out(t);
  endtask

  task automatic run(input int n, input int gap, input string t);
    for (int i = 0; i < n; i++) begin
      cycle(1'b1, t);
      for (int g = 0; g < gap; g++) cycle(1'b0, "R9");
    end
  endtask

  task automatic restart_with(input int p, input int d, input int b);
    enable = 1'b0;
    cycle(1'b1, "R8");
    period = CNT_W'(p); duty = CNT_W'(d); deadband = DB_W'(b);
    enable = 1'b1;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; enable = 1'b0; tick_en = 1'b0;
    period = '0; duty = '0; deadband = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check_out("R11");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out("R11");

    for (int v = 0; v < NV; v++) begin
      restart_with(VECS[v].p, VECS[v].d, VECS[v].b);
      run(VECS[v].n, VECS[v].gap, tag(VECS[v].req));
    end

    // R2: duty written mid-period applies from the next period
    restart_with(9, 3, 0);
    run(5, 0, "R2");
    duty = 8'd7;
    run(15, 0, "R2");

    // R8: disable mid-run, stay off, then restart at timer 0
    restart_with(9, 5, 1);
    run(6, 0, "R8");
    enable = 1'b0;
    cycle(1'b1, "R8");
    cycle(1'b1, "R8");
    cycle(1'b0, "R8");
    enable = 1'b1;
    run(12, 0, "R8");

    // R9: a long stall in the middle of a pulse
    restart_with(9, 6, 2);
    run(4, 0, "R9");
    for (int i = 0; i < 5; i++) cycle(1'b0, "R9");
    run(10, 0, "R4");

    // R11: reset asserted mid-run
    restart_with(9, 6, 0);
    run(3, 0, "R11");
    rst_n = 1'b0;
    enable = 1'b0;
    #1;
    model_reset();
    check_out("R11");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_out("R11");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule